// File: doc/BRIEF.md
# Cross-Clock Mailbox Register

This block carries one data word from a sender clock domain to a receiver clock domain without passing through any queue. The sender strobes a word in with a select and an enable on its own clock. The block holds the word and raises a mail-present indication on the receiver's clock after a two-flop synchronizer. The receiver takes the word by strobing its own select and enable, which clears the indication. The acknowledge travels back through a second two-flop synchronizer, and the sender then sees the mailbox as free again.

The handshake uses a toggle in each direction. The sender flips a request bit when it accepts a word, and the receiver flips an acknowledge bit when it consumes one. Each side compares its own bit with the synchronized copy of the other side's bit. While mail is outstanding the sender cannot overwrite the stored word. For this reason the word needs no synchronizer of its own: it is stable whenever the receiver is allowed to look at it. For mail in both directions, one instance is used per direction.

Top module: `mbox_xfer`

## Requirements
- R1: After reset, wr_busy is 0, rd_mail is 0 and rd_data is all zeros.
- R2: A write happens on a rising wr_clk edge at which wr_sel and wr_en are both 1 and wr_busy is 0. It stores wr_data, and wr_busy reads 1 right after that edge. With only one of wr_sel or wr_en high, nothing is stored and wr_busy stays 0.
- R3: A write attempted while wr_busy is 1 is ignored. The stored word stays unchanged until the receiver consumes it.
- R4: After an accepted write, rd_mail rises within four rd_clk edges. It never rises without a prior write.
- R5: While rd_mail is 1, rd_data equals the last accepted word and does not change.
- R6: A read happens on a rising rd_clk edge at which rd_sel, rd_en and rd_mail are all 1. It drops rd_mail right after that edge. With only one of rd_sel or rd_en high, rd_mail stays 1.
- R7: After a read, wr_busy returns to 0 within four wr_clk edges.
- R8: A read strobe while rd_mail is 0 has no effect. rd_mail stays 0, and wr_busy stays 0 if no write is outstanding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Sender clock |
| wr_rst_n | input | 1 | Sender-domain reset, active low |
| wr_sel | input | 1 | Sender mailbox select |
| wr_en | input | 1 | Sender write enable |
| wr_data | input | WIDTH | Word to deposit |
| wr_busy | output | 1 | Mail outstanding, sender may not write |
| rd_clk | input | 1 | Receiver clock |
| rd_rst_n | input | 1 | Receiver-domain reset, active low |
| rd_sel | input | 1 | Receiver mailbox select |
| rd_en | input | 1 | Receiver read enable |
| rd_data | output | WIDTH | Stored word |
| rd_mail | output | 1 | New mail present |

## Verification
Each toggle bit is a single state bit, so any corruption in it shows up quickly at the ports. A request toggle that flips wrongly makes rd_mail appear or vanish within two receiver cycles. An acknowledge toggle that flips wrongly leaves wr_busy stuck, or frees the sender early, within two sender cycles. A capture that ignores wr_busy shows up as a changed rd_data while rd_mail is still high, and this is visible at the very next read. The random traffic mixes partial strobes, writes while busy and reads while empty with these observation points, on two clocks that are not related.

// File: rtl/mbox_xfer.sv
module mbox_xfer #(
  parameter int WIDTH = 36,
  parameter int SYNC  = 2
) (
  input  logic             wr_clk,
  input  logic             wr_rst_n,
  input  logic             wr_sel,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic             wr_busy,
  input  logic             rd_clk,
  input  logic             rd_rst_n,
  input  logic             rd_sel,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_mail
);

  logic [WIDTH-1:0] word_q;
  logic             req_q, ack_q;
  logic [SYNC-1:0]  req_s, ack_s;
  logic             put, take;

  assign wr_busy = req_q ^ ack_s[SYNC-1];
  assign rd_mail = req_s[SYNC-1] ^ ack_q;
  assign rd_data = word_q;
  assign put     = wr_sel & wr_en & ~wr_busy;
  assign take    = rd_sel & rd_en & rd_mail;

  always_ff @(posedge wr_clk or negedge wr_rst_n)
    if (!wr_rst_n) begin
      word_q <= '0;
      req_q  <= 1'b0;
      ack_s  <= '0;
    end else begin
      ack_s <= {ack_s[SYNC-2:0], ack_q};
      if (put) begin
        word_q <= wr_data;
        req_q  <= ~req_q;
      end
    end

  always_ff @(posedge rd_clk or negedge rd_rst_n)
    if (!rd_rst_n) begin
      ack_q <= 1'b0;
      req_s <= '0;
    end else begin
      req_s <= {req_s[SYNC-2:0], req_q};
      if (take) ack_q <= ~ack_q;
    end

  p_busy_after_put_r2: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (wr_sel && wr_en && !wr_busy) |=> wr_busy);

  p_word_held_r3: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    wr_busy |=> $stable(word_q));

  p_mail_kept_r6: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rd_mail && !(rd_sel && rd_en)) |=> rd_mail);

  p_mail_cleared_r6: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rd_mail && rd_sel && rd_en) |=> !rd_mail);

  p_data_stable_r5: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rd_mail && !(rd_sel && rd_en)) |=> $stable(rd_data));

  initial begin
    if (SYNC < 2) $error("p_sync_depth_r4: SYNC must be at least 2");
  end

endmodule

// File: tb/mbox_xfer_tb.sv
module mbox_xfer_tb;
  localparam int W = 36;

  logic         wr_clk = 0, rd_clk = 0;
  logic         wr_rst_n = 0, rd_rst_n = 0;
  logic         wr_sel = 0, wr_en = 0, rd_sel = 0, rd_en = 0;
  logic [W-1:0] wr_data = '0;
  logic         wr_busy, rd_mail;
  logic [W-1:0] rd_data;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 wr_clk = ~wr_clk;
  always #5.5 rd_clk = ~rd_clk;

  mbox_xfer u_dut (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_sel(wr_sel), .wr_en(wr_en),
    .wr_data(wr_data), .wr_busy(wr_busy),
    .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_sel(rd_sel), .rd_en(rd_en),
    .rd_data(rd_data), .rd_mail(rd_mail)
  );

  function automatic logic [W-1:0] pick_word(int i);
    case (i)
      0: return '1;
      1: return '0;
      2: return {18{2'b10}};
      3: return {W{1'b0}} | 1;
      default: return {$urandom, $urandom} & {W{1'b1}};
    endcase
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_cycle(logic s, logic e, logic [W-1:0] d);
    @(negedge wr_clk);
    wr_sel = s; wr_en = e; wr_data = d;
    @(negedge wr_clk);
    wr_sel = 0; wr_en = 0;
  endtask

  task automatic rd_cycle(logic s, logic e);
    @(negedge rd_clk);
    rd_sel = s; rd_en = e;
    @(negedge rd_clk);
    rd_sel = 0; rd_en = 0;
  endtask

  task automatic wait_free();
    int n = 0;
    while (wr_busy && n < 4) begin @(negedge wr_clk); n++; end
    check("R7", W'(wr_busy), '0);
  endtask

  task automatic wait_mail();
    int n = 0;
    while (!rd_mail && n < 4) begin @(negedge rd_clk); n++; end
    check("R4", W'(rd_mail), W'(1));
  endtask

  initial begin
    int guard = 0;
    while (!done) begin
      @(posedge wr_clk);
      guard++;
      if (guard > 150000) begin
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [W-1:0] w;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge wr_clk);
    wr_rst_n = 1; rd_rst_n = 1;
    @(negedge rd_clk);
    check("R1", W'(wr_busy), '0);
    check("R1", W'(rd_mail), '0);
    check("R1", rd_data, '0);

    rd_cycle(1, 1);
    check("R8", W'(rd_mail), '0);
    repeat (4) @(negedge wr_clk);
    check("R8", W'(wr_busy), '0);

    for (int i = 0; i < 80; i++) begin
      w = pick_word(i);
      if ($urandom_range(0, 1)) begin
        wr_cycle(1'b1, 1'b0, ~w);
        check("R2", W'(wr_busy), '0);
        wr_cycle(1'b0, 1'b1, ~w);
        check("R2", W'(wr_busy), '0);
      end
      wr_cycle(1, 1, w);
      check("R2", W'(wr_busy), W'(1));
      if ($urandom_range(0, 1)) begin
        wr_cycle(1, 1, ~w);
        check("R3", W'(wr_busy), W'(1));
      end
      wait_mail();
      check("R5", rd_data, w);
      for (int k = 0; k < int'($urandom_range(0, 3)); k++) begin
        if ($urandom_range(0, 1)) rd_cycle(1, 0); else rd_cycle(0, 1);
        check("R6", W'(rd_mail), W'(1));
        check("R5", rd_data, w);
      end
      if ($urandom_range(0, 1)) begin
        wr_cycle(1, 1, pick_word(i + 7));
        check("R3", rd_data, w);
      end
      rd_cycle(1, 1);
      check("R6", W'(rd_mail), '0);
      check("R3", rd_data, w);
      wait_free();
      if (i % 10 == 0) begin
        rd_cycle(1, 1);
        check("R8", W'(rd_mail), '0);
        repeat (4) @(negedge wr_clk);
        check("R8", W'(wr_busy), '0);
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule